// File: doc/BRIEF.md
# Dual-Path Latching Bus Transceiver

This block moves data between two parallel buses, A and B, of parameterizable width (18 bits by default). Each direction has its own storage element and its own four controls: an active-low output enable, an active-high pass-through (latch) enable, a storage strobe, and an active-low strobe enable. Depending on these controls, a path's storage is transparent, holds its value, or captures the source bus on a rising strobe. The stored value is sent, non-inverted, toward the opposite bus.

The design is fully synchronous to a fast system clock `clk`. The storage strobes are plain data inputs: each is sampled every system cycle, and a rising edge is a 0-to-1 change between two consecutive samples. Each tri-state bus port is split into a data output and an active-high drive flag. A conflict flag rises whenever both directions would drive at once. A synchronous reset clears both storage registers.

Top module: `bus_xcvr`

## Requirements
- R1: While a path's latch enable is 1, its output data equals the source bus sampled at the previous rising edge of `clk`. The strobe and the strobe enable have no effect in this mode.
- R2: A path's drive flag is the inverse of its output enable in the same cycle, whatever the other controls are. The data output is a non-inverted copy of the stored value and is shown even while the path is not driving.
- R3: With latch enable 0 and strobe enable 0, a strobe that is sampled 0 in one cycle and 1 in the next stores the source bus present in the cycle where the 1 is sampled. The new value appears on the output after the following `clk` edge.
- R4: With latch enable 0 and strobe enable 1, rising strobes are ignored and the stored value stays unchanged.
- R5: With latch enable 0 and the strobe held steady at 0 or at 1, the stored value stays unchanged even if the source bus changes.
- R6: When latch enable falls, the storage keeps the last value that passed through it.
- R7: `conflict` is 1 exactly when both drive flags are 1.
- R8: While `rst` is 1, a `clk` edge clears both stored values to 0. A strobe that is already 1 when reset is released is not treated as a rising edge.
- R9: The two directions are independent. The controls and source bus of one path never change the other path's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Bus A data, source for the A-to-B path |
| b_in | input | W | Bus B data, source for the B-to-A path |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (transparent when 1) |
| ab_stb | input | 1 | A-to-B storage strobe |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (transparent when 1) |
| ba_stb | input | 1 | B-to-A storage strobe |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |
| b_out | output | W | Data toward bus B |
| b_drv | output | 1 | Drive flag for bus B |
| a_out | output | W | Data toward bus A |
| a_drv | output | 1 | Drive flag for bus A |
| conflict | output | 1 | Both directions driving at once |

## Verification
The hardest case to reach from the ports is a rising strobe that must be ignored: one that arrives while the strobe enable is inactive, one that arrives during pass-through, or a strobe that is already high as reset is released. Each of these looks like a capture unless the sample history is correct. The stimulus sets up each case deliberately. It changes the source bus in the same cycle as the strobe transition, so any wrong capture shows up as a data mismatch, and it runs the other direction on a different pattern at the same time to expose any crosstalk between paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD = 2'd0,
      MODE_PASS = 2'd1,
      MODE_CAPT = 2'd2
   } store_mode_e;

   localparam int unsigned NUM_PATHS = 2;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   output logic rise
);
   logic prev_q;

   // Reload with the live strobe during reset so that a level already high
   // at release does not look like an edge.
   always_ff @(posedge clk) begin
      prev_q <= strobe;
   end

   assign rise = strobe & ~prev_q & ~rst;
endmodule

// File: rtl/lane_store.sv
module lane_store #(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   input  logic         le,
   input  logic         stb,
   input  logic         stb_en_n,
   output logic [W-1:0] q
);
   import xcvr_pkg::*;

   logic        rise;
   store_mode_e mode;
   logic [W-1:0] store_q;

   strobe_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .strobe(stb),
      .rise  (rise)
   );

   always_comb begin
      if (le)                   mode = MODE_PASS;
      else if (rise && !stb_en_n) mode = MODE_CAPT;
      else                      mode = MODE_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         store_q <= '0;
      end else begin
         unique case (mode)
            MODE_PASS, MODE_CAPT: store_q <= din;
            default:              store_q <= store_q;
         endcase
      end
   end

   assign q = store_q;

   p_pass_r1: assert property (@(posedge clk) disable iff (rst)
      le |=> q == $past(din));
   p_capt_r3: assert property (@(posedge clk) disable iff (rst)
      (!le && !stb_en_n && stb && !$past(stb)) |=> q == $past(din));
   p_ceign_r4: assert property (@(posedge clk) disable iff (rst)
      (!le && stb_en_n) |=> q == $past(q));
   p_steady_r5: assert property (@(posedge clk) disable iff (rst)
      (!le && $stable(stb)) |=> q == $past(q));
   p_rst_r8: assert property (@(posedge clk)
      rst |=> q == '0);
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
   parameter int unsigned W         = 18,
   parameter bit          PARK_ZERO = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         ab_oe_n,
   input  logic         ab_le,
   input  logic         ab_stb,
   input  logic         ab_stb_en_n,
   input  logic         ba_oe_n,
   input  logic         ba_le,
   input  logic         ba_stb,
   input  logic         ba_stb_en_n,
   output logic [W-1:0] b_out,
   output logic         b_drv,
   output logic [W-1:0] a_out,
   output logic         a_drv,
   output logic         conflict
);
   import xcvr_pkg::*;

   localparam int unsigned NP = NUM_PATHS;

   if (W < 1) begin : g_bad_width
      $error("bus_xcvr: W must be at least 1");
   end

   // index 0: A-to-B, index 1: B-to-A
   logic [W-1:0] src   [NP];
   logic [W-1:0] held  [NP];
   logic [W-1:0] shown [NP];
   logic [NP-1:0] le_v, stb_v, en_n_v, oe_n_v, drv_v;

   assign src[0] = a_in;
   assign src[1] = b_in;
   assign le_v   = {ba_le, ab_le};
   assign stb_v  = {ba_stb, ab_stb};
   assign en_n_v = {ba_stb_en_n, ab_stb_en_n};
   assign oe_n_v = {ba_oe_n, ab_oe_n};

   for (genvar g = 0; g < NP; g++) begin : g_path
      lane_store #(.W(W)) u_lane (
         .clk     (clk),
         .rst     (rst),
         .din     (src[g]),
         .le      (le_v[g]),
         .stb     (stb_v[g]),
         .stb_en_n(en_n_v[g]),
         .q       (held[g])
      );

      assign drv_v[g] = ~oe_n_v[g];

      if (PARK_ZERO) begin : g_park
         assign shown[g] = drv_v[g] ? held[g] : '0;
      end else begin : g_show
         assign shown[g] = held[g];
      end
   end

   assign b_out    = shown[0];
   assign b_drv    = drv_v[0];
   assign a_out    = shown[1];
   assign a_drv    = drv_v[1];
   assign conflict = &drv_v;

   p_oe_r2: assert property (@(posedge clk) disable iff (rst)
      (ab_oe_n |-> !b_drv) and (ba_oe_n |-> !a_drv));
   p_conf_r7: assert property (@(posedge clk) disable iff (rst)
      conflict |-> (!ab_oe_n && !ba_oe_n));
   p_indep_r9: assert property (@(posedge clk) disable iff (rst)
      (!ab_le && ab_stb_en_n) |=> $stable(b_out));
endmodule

// File: tb/bus_xcvr_tb.sv
module bus_xcvr_tb;
   localparam int unsigned W = 18;

   typedef struct packed {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         ad;
      logic         bd;
      logic         cf;
   } obs_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_stb = 1'b0, ab_stb_en_n = 1'b1;
   logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_stb = 1'b0, ba_stb_en_n = 1'b1;
   logic [W-1:0] b_out, a_out;
   logic b_drv, a_drv, conflict;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   obs_t  exp_q[$];
   string tag_q[$];

   // reference state
   logic [W-1:0] m_ab = '0, m_ba = '0;
   logic m_ab_prev = 1'b0, m_ba_prev = 1'b0;

   always #5 clk = ~clk;

   bus_xcvr #(.W(W)) u_dut (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
      .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n),
      .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv), .conflict(conflict)
   );

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // inputs are already set; apply the model for the coming edge and queue
   task automatic step(string tag);
      obs_t e;
      if (rst) begin
         m_ab = '0; m_ba = '0;
      end else begin
         if (ab_le || (!ab_stb_en_n && ab_stb && !m_ab_prev)) m_ab = a_in;
         if (ba_le || (!ba_stb_en_n && ba_stb && !m_ba_prev)) m_ba = b_in;
      end
      m_ab_prev = ab_stb;
      m_ba_prev = ba_stb;
      e.b  = m_ab;
      e.a  = m_ba;
      e.bd = !ab_oe_n;
      e.ad = !ba_oe_n;
      e.cf = !ab_oe_n && !ba_oe_n;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   // monitor: sample after the edge, well before the next input change
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         obs_t e, g;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         g = '{a: a_out, b: b_out, ad: a_drv, bd: b_drv, cf: conflict};
         total++;
         if (g !== e) begin
            bad++;
            $display("FAIL %s: actual a=%h b=%h ad=%b bd=%b cf=%b expected a=%h b=%h ad=%b bd=%b cf=%b",
                     t, g.a, g.b, g.ad, g.bd, g.cf, e.a, e.b, e.ad, e.bd, e.cf);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      // R8: reset with strobes high and data present
      rst = 1; ab_stb = 1; ab_stb_en_n = 0; a_in = 18'h3FFFF; b_in = 18'h15555;
      step("R8 reset"); step("R8 reset");
      rst = 0;
      step("R8 no edge on release");
      // R2: drive flags track output enables
      ab_oe_n = 0; step("R2 ab drive");
      ab_oe_n = 1; ba_oe_n = 0; step("R2 ba drive");
      // R7 conflict
      ab_oe_n = 0; step("R7 both drive");
      // R1 pass-through with noise on strobe/enable
      ab_le = 1;
      for (int i = 0; i < 6; i++) begin
         a_in = W'($urandom); ab_stb = i[0]; ab_stb_en_n = i[1];
         step("R1 pass");
      end
      // R6 latch enable falls, data keeps changing
      ab_le = 0; ab_stb_en_n = 1; a_in = 18'h0BEEF; step("R6 close");
      a_in = 18'h12345; step("R6 keep"); step("R6 keep");
      // R3 capture, other path running its own pattern (R9)
      ab_stb = 0; ab_stb_en_n = 0; step("R3 low");
      ba_le = 1; b_in = 18'h2AAAA;
      ab_stb = 1; a_in = 18'h31337; step("R3 capture");
      ba_le = 0;
      // R5 strobe held high, data changing
      for (int i = 0; i < 4; i++) begin
         a_in = W'($urandom); b_in = W'($urandom); step("R5 steady high");
      end
      ab_stb = 0;
      for (int i = 0; i < 3; i++) begin
         a_in = W'($urandom); step("R5 steady low");
      end
      // R4 strobe edges with enable inactive
      ab_stb_en_n = 1;
      for (int i = 0; i < 6; i++) begin
         ab_stb = ~ab_stb; a_in = W'($urandom); step("R4 ignored");
      end
      // R9 B-to-A capture while A-to-B pass-through
      ab_le = 1; ba_stb = 0; ba_stb_en_n = 0; step("R9 setup");
      ba_stb = 1; b_in = 18'h0F0F0; a_in = 18'h20202; step("R9 ba capture");
      ba_stb = 0; b_in = 18'h11111; step("R9 ba hold");
      // mixed random stress of all rows
      for (int i = 0; i < 300; i++) begin
         logic [9:0] r;
         r = 10'($urandom);
         {ab_oe_n, ab_le, ab_stb, ab_stb_en_n, ba_oe_n} = r[4:0];
         {ba_le, ba_stb, ba_stb_en_n} = r[7:5];
         ab_le = ab_le & r[8]; ba_le = ba_le & r[9];
         a_in = W'($urandom); b_in = W'($urandom);
         step("R9 mixed");
      end
      // R8 reset again mid-run
      rst = 1; step("R8 reset again");
      rst = 0; ab_le = 0; ba_le = 0; step("R8 after");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule